// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is a target on a two-wire serial management bus (SMBus/I2C compatible) that gives a host controller access to a bank of byte-wide configuration registers. The host can write or read a single indexed register, or stream a block of registers starting from register zero. The contents of every register are presented in parallel on a flat output vector, so that the rest of the chip can use them as static configuration.

The clock and data lines arrive already synchronized to the system clock. The target never drives the data line high: it only pulls it low through an open-drain enable. A command byte sent after the address decides the access type. With bit 7 set, the access is to a single register, and the low seven bits give the register index. With bit 7 clear, the access is a block access that starts at register zero. One register holds the byte count that limits how far a block read goes. Power-up and reset values come from a parameter, and a parameter mask marks the identification registers as read-only.

Top module: `smbcfg_target`

## Requirements
- R1: The target acknowledges the address byte 0xD2 (7-bit address 0x69, with bit 0 giving the direction, 0 for write and 1 for read). Any other address gets no acknowledge, and the rest of that transfer changes no register.
- R2: A write whose command byte has bit 7 = 1 stores the following data byte in the register indexed by command bits 6:0.
- R3: A byte read, made of a write of the command (bit 7 = 1), a repeated start, the read address 0xD3 and one byte clocked out MSB first, returns the indexed register.
- R4: A block write (command 0x00, then a byte count, then data) stores the data bytes into registers 0, 1, 2 and upward in order. The byte count itself is not stored. The address, the command, the count and every data byte are acknowledged.
- R5: A block read (command 0x00, repeated start, read address) first returns the value of register 12 as the byte count. It then returns registers 0, 1, 2 and upward. Data byte k is a register value only when k is less than that count, and 0xFF otherwise.
- R6: A stop after any complete byte ends the transfer, and the registers already written keep their new values.
- R7: Reset (synchronous, active low) loads every register from parameter REG_INIT. With the default parameters, register 12 is 0x0F and register 4 is 0x6E (output enables at bits 6, 5, 3 and 2, spread enable at bit 1).
- R8: Registers 7, 8 and 14 are read-only. Writes to them are acknowledged and have no effect.
- R9: When the host does not acknowledge a read byte, the target stops transmitting and leaves the data line released until the next start condition.
- R10: The target changes its data-line drive only while the clock line is low, and it releases the line in the host's acknowledge slot.
- R11: Indices at or above the register count (16 by default) are acknowledged on write without effect and read back as 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, already synchronized |
| sda_i | input | 1 | Bus data line, already synchronized |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| cfg_o | output | NUM_REGS*8 | All register contents, register i at bits i*8+7:i*8 |

## Verification
A vector table pairs single-register writes with read-backs at a plain index, the lowest and highest indices, the read-only indices and an index beyond the bank. These vectors separate working index decoding from write protection and from out-of-range handling. Block writes with a full and a truncated payload separate sequential storage from early termination. Block reads at the default and at a raised byte count show whether the count byte and the 0xFF padding follow register 12. A foreign address, a read that the host refuses to acknowledge and a mid-run reset show whether transfers are rejected, the line is released and the defaults return.

// File: rtl/smbcfg_pkg.sv
// Shared types for the two-wire configuration target.
// Assumes: command index field is seven bits wide, as set by the bus format.
package smbcfg_pkg;
    localparam int OFS_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,  // waiting for a start condition
        ST_RX,    // shifting in an address or write byte
        ST_ACK,   // target pulls data low for one bit
        ST_TX,    // shifting out a read byte
        ST_TACK,  // host acknowledge slot, line released
        ST_SKIP   // transfer not for us or ended by host refusal
    } eng_state_t;
endpackage

// File: rtl/smbcfg_cond.sv
// Bus condition detector: finds clock edges and start/stop conditions.
// Assumes: scl_i and sda_i are synchronized and the system clock is
// many times faster than the bus clock.
module smbcfg_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Keep last sampled line levels; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_lvl   = scl_q;
    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smbcfg_regs.sv
// Register bank: NUM_REGS bytes, reset from REG_INIT, bits of RO_MASK
// pick constant read-only registers. Reads outside the bank give 0xFF.
// Assumes: at most one write strobe per cycle.
module smbcfg_regs #(
    parameter int                    NUM_REGS = 16,
    parameter int                    CNT_IDX  = 12,
    parameter logic [NUM_REGS-1:0]   RO_MASK  = '0,
    parameter logic [NUM_REGS*8-1:0] REG_INIT = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [smbcfg_pkg::OFS_W-1:0]  wr_idx,
    input  logic [7:0]                    wr_data,
    input  logic [smbcfg_pkg::OFS_W-1:0]  rd_idx,
    output logic [7:0]                    rd_data,
    output logic [7:0]                    cnt_val,
    output logic [NUM_REGS*8-1:0]         regs_o
);
    localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS*8-1:0] flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (RO_MASK[g]) begin : g_ro
            // Read-only register: fixed at its initial value.
            assign flat[g*8 +: 8] = REG_INIT[g*8 +: 8];
        end else begin : g_rw
            logic [7:0] q;
            // Writable register: reset to default, load on matching strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= REG_INIT[g*8 +: 8];
                else if (wr_en && (int'(wr_idx) == g))
                    q <= wr_data;
            end
            assign flat[g*8 +: 8] = q;
        end
    end

    // Read mux with out-of-range padding.
    always_comb begin
        if (int'(rd_idx) < NUM_REGS)
            rd_data = flat[rd_idx[IW-1:0]*8 +: 8];
        else
            rd_data = 8'hFF;
    end

    assign cnt_val = flat[CNT_IDX*8 +: 8];
    assign regs_o  = flat;

    // R7: the first cycle after reset shows the default image.
    a_r7_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (regs_o == REG_INIT));
endmodule

// File: rtl/smbcfg_engine.sv
// Protocol engine: address match, acknowledge, command decode, byte
// count handling and index auto-increment for byte and block access.
// Assumes: edge and condition strobes from smbcfg_cond, read data
// available combinationally for the current index.
module smbcfg_engine
    import smbcfg_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_i,
    input  logic             scl_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       cnt_val,
    output logic [OFS_W-1:0] ptr_o,
    output logic             wr_en_o,
    output logic [OFS_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    output logic             sda_oe_o
);
    eng_state_t       state;
    logic [7:0]       sh;
    logic [3:0]       bcnt;
    logic             got, is_addr, rd_mode, cmd_next, cnt_first, blk, nack;
    logic [OFS_W-1:0] ptr;
    logic [7:0]       tx_byte;

    // Choose the next byte to send: count first, then limited data.
    always_comb begin
        if (cnt_first)
            tx_byte = cnt_val;
        else if (blk && !(8'(ptr) < cnt_val))
            tx_byte = 8'hFF;
        else
            tx_byte = rd_data;
    end

    // Bit and byte sequencing of the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sh        <= '0;
            bcnt      <= '0;
            got       <= 1'b0;
            is_addr   <= 1'b0;
            rd_mode   <= 1'b0;
            cmd_next  <= 1'b0;
            cnt_first <= 1'b0;
            blk       <= 1'b0;
            nack      <= 1'b0;
            ptr       <= '0;
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_det) begin
                state   <= ST_RX;
                is_addr <= 1'b1;
                bcnt    <= '0;
                got     <= 1'b0;
            end else if (stop_det) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && !got) begin
                            sh   <= {sh[6:0], sda_i};
                            bcnt <= bcnt + 4'd1;
                            if (bcnt == 4'd7) got <= 1'b1;
                        end else if (scl_fall && got) begin
                            got  <= 1'b0;
                            bcnt <= '0;
                            if (is_addr) begin
                                is_addr <= 1'b0;
                                if (sh[7:1] == ADDR7) begin
                                    state    <= ST_ACK;
                                    rd_mode  <= sh[0];
                                    cmd_next <= ~sh[0];
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else begin
                                state <= ST_ACK;
                                if (cmd_next) begin
                                    cmd_next  <= 1'b0;
                                    blk       <= ~sh[7];
                                    cnt_first <= ~sh[7];
                                    ptr       <= sh[7] ? sh[6:0] : '0;
                                end else if (cnt_first) begin
                                    cnt_first <= 1'b0;
                                end else begin
                                    wr_en_o  <= 1'b1;
                                    wr_idx_o <= ptr;
                                    ptr      <= ptr + 1'b1;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (rd_mode) begin
                                sh    <= tx_byte;
                                bcnt  <= '0;
                                state <= ST_TX;
                                if (cnt_first) cnt_first <= 1'b0;
                                else           ptr <= ptr + 1'b1;
                            end else begin
                                state <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            sh   <= {sh[6:0], 1'b1};
                            bcnt <= bcnt + 4'd1;
                            if (bcnt == 4'd7) state <= ST_TACK;
                        end
                    end
                    ST_TACK: begin
                        if (scl_rise) nack <= sda_i;
                        if (scl_fall) begin
                            if (nack) begin
                                state <= ST_SKIP;
                            end else begin
                                sh    <= tx_byte;
                                bcnt  <= '0;
                                state <= ST_TX;
                                if (cnt_first) cnt_first <= 1'b0;
                                else           ptr <= ptr + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Open-drain drive: acknowledge low, or the current data bit.
    always_comb begin
        case (state)
            ST_ACK:  sda_oe_o = 1'b1;
            ST_TX:   sda_oe_o = ~sh[7];
            default: sda_oe_o = 1'b0;
        endcase
    end

    assign ptr_o     = ptr;
    assign wr_data_o = sh;

    // R10: the target starts pulling the line only while the clock is low.
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_lvl);
    // R4: every stored data byte is acknowledged while it is written.
    a_r4_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> sda_oe_o);
    // R6: a stop always returns the engine to idle.
    a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));
endmodule

// File: rtl/smbcfg_target.sv
// Top of the two-wire configuration target: wires the condition
// detector, protocol engine and register bank together.
// Assumes: bus lines synchronized upstream; data pad is open drain.
module smbcfg_target #(
    parameter int                    NUM_REGS = 16,
    parameter logic [6:0]            ADDR7    = 7'h69,
    parameter int                    CNT_IDX  = 12,
    parameter logic [NUM_REGS-1:0]   RO_MASK  = 16'h4180,
    parameter logic [NUM_REGS*8-1:0] REG_INIT =
        128'h00A5FC0F_07032580_4800006E_FFFF05A1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    import smbcfg_pkg::*;

    logic             scl_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]       rd_data, cnt_val, wr_data;
    logic [OFS_W-1:0] ptr, wr_idx;
    logic             wr_en;

    smbcfg_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smbcfg_engine #(.ADDR7(ADDR7)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .scl_lvl(scl_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .cnt_val(cnt_val), .ptr_o(ptr),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
        .sda_oe_o(sda_oe_o)
    );

    smbcfg_regs #(
        .NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX),
        .RO_MASK(RO_MASK), .REG_INIT(REG_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(ptr), .rd_data(rd_data),
        .cnt_val(cnt_val), .regs_o(cfg_o)
    );
endmodule

// File: tb/smbcfg_target_test.sv
module smbcfg_target_test;
    localparam int HB = 10;  // system clocks per bus half period
    localparam logic [127:0] TB_INIT = 128'h00A5FC0F_07032580_4800006E_FFFF05A1;
    // {index, write value, expected read-back}
    localparam logic [23:0] VEC [6] = '{
        24'h03_5A_5A, 24'h00_C3_C3, 24'h0F_E7_E7,
        24'h07_12_48, 24'h0E_33_A5, 24'h14_77_FF
    };

    logic clk = 1'b0, rst_n = 1'b0, tb_scl = 1'b1, tb_sda = 1'b1;
    logic sda_oe, sda_bus;
    logic [127:0] cfg;
    int checks = 0, failures = 0;
    logic done = 1'b0;
    logic [7:0] model [16];
    logic [7:0] rbuf [20];
    int r10_viol = 0;
    logic scl_p = 1'b1, oe_p = 1'b0;

    always #10 clk = ~clk;
    assign sda_bus = tb_sda & ~sda_oe;

    smbcfg_target uut (.clk(clk), .rst_n(rst_n), .scl_i(tb_scl), .sda_i(sda_bus),
                       .sda_oe_o(sda_oe), .cfg_o(cfg));

    // R10 monitor: drive changes while the clock stays high.
    always @(negedge clk) begin
        if (rst_n && scl_p && tb_scl && (sda_oe != oe_p)) r10_viol++;
        scl_p = tb_scl;
        oe_p  = sda_oe;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n); repeat (n) @(negedge clk); endtask
    task automatic bus_start(); tb_sda = 1; w(HB/2); tb_scl = 1; w(HB/2); tb_sda = 0; w(HB/2); tb_scl = 0; w(HB/2); endtask
    task automatic bus_stop(); tb_sda = 0; w(HB/2); tb_scl = 1; w(HB/2); tb_sda = 1; w(HB); endtask
    task automatic wr_bit(input logic b); tb_sda = b; w(HB/2); tb_scl = 1; w(HB); tb_scl = 0; w(HB/2); endtask
    task automatic rd_bit(output logic b); tb_sda = 1; w(HB/2); tb_scl = 1; w(HB/2); b = sda_bus; w(HB/2); tb_scl = 0; w(HB/2); endtask
    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wr_bit(d[i]);
        rd_bit(b); ack = ~b;
    endtask
    task automatic rd_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin rd_bit(b); d[i] = b; end
        wr_bit(~ack);
    endtask
    task automatic byte_write(input logic [6:0] idx, input logic [7:0] d, output int acks);
        logic a;
        acks = 0;
        bus_start();
        wr_byte(8'hD2, a); acks += int'(a);
        wr_byte({1'b1, idx}, a); acks += int'(a);
        wr_byte(d, a); acks += int'(a);
        bus_stop();
    endtask
    task automatic byte_read(input logic [6:0] idx, output logic [7:0] d);
        logic a;
        bus_start(); wr_byte(8'hD2, a); wr_byte({1'b1, idx}, a);
        bus_start(); wr_byte(8'hD3, a); rd_byte(d, 1'b0);
        bus_stop();
    endtask
    task automatic block_read(input int n);
        logic a;
        bus_start(); wr_byte(8'hD2, a); wr_byte(8'h00, a);
        bus_start(); wr_byte(8'hD3, a);
        for (int i = 0; i < n; i++) rd_byte(rbuf[i], i != n - 1);
        bus_stop();
    endtask
    task automatic check_all_regs(input string tag);
        for (int i = 0; i < 16; i++)
            chk(cfg[i*8 +: 8] == model[i], tag, int'(cfg[i*8 +: 8]), int'(model[i]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic a;
        int acks;
        for (int i = 0; i < 16; i++) model[i] = TB_INIT[i*8 +: 8];
        w(5); rst_n = 1; w(3);

        // R7: reset image and named defaults
        chk(cfg == TB_INIT, "R7 reset image", int'(cfg[31:0]), int'(TB_INIT[31:0]));
        chk(cfg[103:96] == 8'h0F, "R7 count default", int'(cfg[103:96]), 15);
        chk(cfg[39:32] == 8'h6E, "R7 reg4 default", int'(cfg[39:32]), 8'h6E);

        // Vector table: byte write then byte read back (R2 R3 R8 R11)
        for (int i = 0; i < 6; i++) begin
            logic [7:0] o, wv, ev;
            string tag;
            {o, wv, ev} = VEC[i];
            tag = (o == 8'h07 || o == 8'h0E) ? "R8" : (o >= 8'd16) ? "R11" : "R2";
            byte_write(o[6:0], wv, acks);
            chk(acks == 3, "R1 acks on byte write", acks, 3);
            if (o < 8'd16 && o != 8'h07 && o != 8'h0E) model[o[3:0]] = wv;
            byte_read(o[6:0], d);
            chk(d == ev, {tag, " R3 read back"}, int'(d), int'(ev));
        end

        // R1: foreign address rejected, no register change
        bus_start(); wr_byte(8'hA0, a);
        chk(!a, "R1 foreign address nack", int'(a), 0);
        wr_byte(8'h83, a); wr_byte(8'h99, a); bus_stop();
        chk(cfg[31:24] == model[3], "R1 foreign write ignored", int'(cfg[31:24]), int'(model[3]));

        // R4: block write of three bytes
        acks = 0;
        bus_start();
        wr_byte(8'hD2, a); acks += int'(a);
        wr_byte(8'h00, a); acks += int'(a);
        wr_byte(8'h03, a); acks += int'(a);
        wr_byte(8'h11, a); acks += int'(a);
        wr_byte(8'h22, a); acks += int'(a);
        wr_byte(8'h33, a); acks += int'(a);
        bus_stop();
        model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
        chk(acks == 6, "R4 block write acks", acks, 6);
        check_all_regs("R4 block write contents");

        // R6: truncated block write keeps what arrived
        bus_start(); wr_byte(8'hD2, a); wr_byte(8'h00, a); wr_byte(8'h04, a);
        wr_byte(8'h9A, a); bus_stop();
        model[0] = 8'h9A;
        chk(cfg[7:0] == 8'h9A, "R6 first byte kept", int'(cfg[7:0]), 8'h9A);
        chk(cfg[15:8] == 8'h22, "R6 next byte untouched", int'(cfg[15:8]), 8'h22);

        // R5: block read at default count 15
        block_read(18);
        chk(rbuf[0] == 8'h0F, "R5 count byte", int'(rbuf[0]), 15);
        for (int k = 0; k < 17; k++)
            chk(rbuf[k+1] == ((k < 15) ? model[k] : 8'hFF), "R5 block data",
                int'(rbuf[k+1]), int'((k < 15) ? model[k] : 8'hFF));

        // R5: raised count reaches register 15
        byte_write(7'd12, 8'h10, acks);
        model[12] = 8'h10;
        block_read(18);
        chk(rbuf[0] == 8'h10, "R5 raised count byte", int'(rbuf[0]), 16);
        chk(rbuf[16] == model[15], "R5 reg15 now visible", int'(rbuf[16]), int'(model[15]));
        chk(rbuf[17] == 8'hFF, "R5 pad past count", int'(rbuf[17]), 8'hFF);

        // R9: after a refused byte the line stays released
        bus_start(); wr_byte(8'hD2, a); wr_byte(8'h80, a);
        bus_start(); wr_byte(8'hD3, a);
        rd_byte(d, 1'b0);
        chk(d == 8'h9A, "R9 read before refusal", int'(d), 8'h9A);
        rd_byte(d, 1'b0);
        chk(d == 8'hFF, "R9 released after nack", int'(d), 8'hFF);
        bus_stop();

        // R10: drive never changed with the clock high
        chk(r10_viol == 0, "R10 drive changes with clock high", r10_viol, 0);

        // R7: mid-run reset restores defaults
        rst_n = 0; w(3); rst_n = 1; w(3);
        for (int i = 0; i < 16; i++) model[i] = TB_INIT[i*8 +: 8];
        check_all_regs("R7 reset restores defaults");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule